// File: doc/BRIEF.md
# Mains-Locked Thyristor Firing Pulse Generator

This block produces one gate pulse per mains half cycle for a thyristor or triac stage. A zero-crossing comparator output enters on `zcRaw`. It is synchronised to the system clock, filtered against short spikes, and then qualified by a hold-off window so that ringing near the crossing cannot restart the half cycle. Each qualified crossing, rising or falling, re-arms a delay counter. The counter runs in coarse ticks of 10 µs at the default settings. When the count reaches the firing-delay setpoint, a gate pulse of fixed tick length is issued.

The setpoint is captured only at a qualified crossing, so a half cycle always uses one consistent angle. The block measures the length of each half cycle. When the captured delay does not fit inside the last measured half cycle, the block does not fire in that half cycle, so a late pulse cannot spill into the next one. When crossings stop, the gate is held off and the mains-present flag drops.

A hardware fault input blanks the gate combinationally, with no clock edge in the path. It also sets a latch that keeps the gate off until the fault has gone and a clear pulse arrives. Choosing the firing angle and driving the thyristor gate in analog form are left to neighbouring blocks.

Top module: `mains_fire_gen`

## Requirements
- R1: While reset is asserted and directly after it, `gateOut` is 0 and `mainsOk` is 0.
- R2: After each qualified zero crossing, whether the `zcRaw` edge is rising or falling, with setpoint d (in ticks) captured at that crossing, `gateOut` rises between (d+1)·CLKS_PER_TICK and (d+1)·CLKS_PER_TICK + DEB_CLKS + 8 clock cycles after the raw edge.
- R3: Exactly one gate pulse is produced per half cycle, and it is high for exactly PULSE_TICKS·CLKS_PER_TICK clock cycles.
- R4: A change on `zcRaw` that lasts fewer than DEB_CLKS clock cycles has no effect on pulse timing or count.
- R5: A filtered `zcRaw` edge that arrives within BLANK_TICKS ticks of the last qualified crossing is ignored and does not restart the delay.
- R6: `delaySet` is captured only at a qualified crossing. A change in mid half cycle takes effect from the next half cycle.
- R7: When the captured delay is not smaller than the tick count of the previous half cycle, no pulse is issued in that half cycle. Because no length has been measured yet, no pulse is issued in the first half cycle after reset or after mains loss.
- R8: If no qualified crossing arrives for LOSS_TICKS ticks, `mainsOk` drops to 0 and `gateOut` stays 0. `mainsOk` returns to 1 at the next qualified crossing.
- R9: While `faultIn` is 1, `gateOut` is 0 in the same time step, with no clock edge in the path.
- R10: After a fault, `gateOut` stays 0 until `faultIn` is 0 and a `faultClr` pulse has been given. A clear given while `faultIn` is still 1 has no effect.
- R11: While `enable` is 0, no gate pulse is issued. Pulses resume once `enable` is 1 again.
- R12: Timing holds for half cycles of both 50 Hz and 60 Hz proportions, which are 100 and 83 ticks in the bench configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| zcRaw | input | 1 | Raw zero-crossing comparator output; each edge marks a half cycle start |
| delaySet | input | DELAY_W | Firing delay in ticks from the crossing |
| enable | input | 1 | Allows pulses when 1 |
| faultIn | input | 1 | Hardware fault; blanks the gate at once |
| faultClr | input | 1 | Single-cycle clear of the fault latch |
| gateOut | output | 1 | Gate pulse to the driver |
| mainsOk | output | 1 | 1 while qualified crossings keep arriving |

## Verification
The firing delay is swept over most of the usable range, at both a 100-tick and an 83-tick half cycle. This separates correct delay counting and re-arming on both edge polarities from any off-by-one in the tick prescaler. Setpoints on both sides of the measured half-cycle length show whether a setpoint that does not fit is suppressed rather than fired late. Short spikes and longer glitches are injected at positions just after the crossing and well inside the half cycle, which separates the spike filter from the hold-off window. Sequences for fault, clear, enable and silent mains check that each inhibit path holds the gate off and releases it only under its own condition.

// File: rtl/mfg_pkg.sv
`timescale 1ns/1ps
package mfg_pkg;
  // Strobes from control to datapath, all valid for one clock
  typedef struct packed {
    logic zcAccept;   // qualified zero crossing, re-arm the half cycle
    logic tick;       // coarse timing tick
    logic lost;       // mains currently considered absent
    logic inhibit;    // any reason to keep the gate off
  } fireStrb_t;
endpackage

// File: rtl/mfg_ctrl.sv
`timescale 1ns/1ps
module mfg_ctrl
  import mfg_pkg::*;
#(
  parameter int CLKS_PER_TICK = 2000,
  parameter int DEB_CLKS      = 64,
  parameter int BLANK_TICKS   = 200,
  parameter int LOSS_TICKS    = 1500
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      zcRaw,
  input  logic      enable,
  input  logic      faultIn,
  input  logic      faultClr,
  output fireStrb_t strb,
  output logic      mainsLost,
  output logic      faultLatch
);
  localparam int PRE_W = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  localparam int DEB_W = $clog2(DEB_CLKS + 1);
  localparam int BLK_W = $clog2(BLANK_TICKS + 1);
  localparam int LOS_W = $clog2(LOSS_TICKS + 1);

  logic [1:0]       zcSync;
  logic [1:0]       faultSync;
  logic             zcS;
  logic             faultS;
  logic             zcStable;
  logic [DEB_W-1:0] debCnt;
  logic             debDone;
  logic             zcAcceptQ;
  logic [BLK_W-1:0] blankCnt;
  logic [PRE_W-1:0] presc;
  logic             tick;
  logic [LOS_W-1:0] lossCnt;

  // two-flop synchronisers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      zcSync    <= '0;
      faultSync <= '0;
    end else begin
      zcSync    <= {zcSync[0], zcRaw};
      faultSync <= {faultSync[0], faultIn};
    end
  end
  assign zcS    = zcSync[1];
  assign faultS = faultSync[1];

  // spike filter: level must differ for DEB_CLKS cycles in a row
  assign debDone = (zcS != zcStable) && (debCnt == DEB_W'(DEB_CLKS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      zcStable <= 1'b0;
      debCnt   <= '0;
    end else if (zcS == zcStable) begin
      debCnt <= '0;
    end else if (debDone) begin
      zcStable <= zcS;
      debCnt   <= '0;
    end else begin
      debCnt <= debCnt + 1'b1;
    end
  end

  // hold-off window after each qualified crossing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      zcAcceptQ <= 1'b0;
      blankCnt  <= '0;
    end else begin
      zcAcceptQ <= debDone && (blankCnt == '0);
      if (zcAcceptQ)
        blankCnt <= BLK_W'(BLANK_TICKS);
      else if (tick && blankCnt != '0)
        blankCnt <= blankCnt - 1'b1;
    end
  end

  // tick prescaler, phase-aligned to each crossing
  assign tick = (presc == PRE_W'(CLKS_PER_TICK - 1)) && !zcAcceptQ;

  always_ff @(posedge clk) begin
    if (!rstN)
      presc <= '0;
    else if (zcAcceptQ || presc == PRE_W'(CLKS_PER_TICK - 1))
      presc <= '0;
    else
      presc <= presc + 1'b1;
  end

  // mains supervision
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lossCnt   <= '0;
      mainsLost <= 1'b1;
    end else if (zcAcceptQ) begin
      lossCnt   <= '0;
      mainsLost <= 1'b0;
    end else if (tick && lossCnt != LOS_W'(LOSS_TICKS)) begin
      lossCnt <= lossCnt + 1'b1;
      if (lossCnt == LOS_W'(LOSS_TICKS - 1))
        mainsLost <= 1'b1;
    end
  end

  // fault latch: set by fault, released only by clear with fault gone
  always_ff @(posedge clk) begin
    if (!rstN)
      faultLatch <= 1'b0;
    else if (faultS)
      faultLatch <= 1'b1;
    else if (faultClr)
      faultLatch <= 1'b0;
  end

  always_comb begin
    strb.zcAccept = zcAcceptQ;
    strb.tick     = tick;
    strb.lost     = mainsLost;
    strb.inhibit  = mainsLost | faultLatch | faultS | !enable;
  end

  // R5: no second crossing accepted while hold-off runs
  a_r5_blank_rejects: assert property (@(posedge clk) disable iff (!rstN)
    (blankCnt != '0) |=> !zcAcceptQ);

  // R8: a qualified crossing restores mains presence
  a_r8_zc_restores: assert property (@(posedge clk) disable iff (!rstN)
    zcAcceptQ |=> !mainsLost);

  // R10: latch is not released without a clear
  a_r10_latch_holds: assert property (@(posedge clk) disable iff (!rstN)
    (faultLatch && !faultClr) |=> faultLatch);
endmodule

// File: rtl/mfg_datapath.sv
`timescale 1ns/1ps
module mfg_datapath
  import mfg_pkg::*;
#(
  parameter int DELAY_W     = 10,
  parameter int PULSE_TICKS = 10,
  parameter int LOSS_TICKS  = 1500
) (
  input  logic               clk,
  input  logic               rstN,
  input  fireStrb_t          strb,
  input  logic [DELAY_W-1:0] delaySet,
  output logic               gatePulse
);
  localparam int CNT_W = $clog2(LOSS_TICKS + 1);
  localparam int PUL_W = $clog2(PULSE_TICKS + 1);
  localparam int CMP_W = (DELAY_W > CNT_W) ? DELAY_W : CNT_W;

  logic [DELAY_W-1:0] delayLat;
  logic [DELAY_W-1:0] delayCnt;
  logic [CNT_W-1:0]   halfCnt;
  logic [CNT_W-1:0]   periodLat;
  logic [PUL_W-1:0]   pulseCnt;
  logic               fired;
  logic               fitsHalf;
  logic               fireNow;

  assign fitsHalf  = CMP_W'(delayLat) < CMP_W'(periodLat);
  assign fireNow   = strb.tick && !fired && !strb.inhibit && fitsHalf &&
                     (delayCnt == delayLat);
  assign gatePulse = (pulseCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      delayLat  <= '0;
      delayCnt  <= '0;
      halfCnt   <= '0;
      periodLat <= '0;
      pulseCnt  <= '0;
      fired     <= 1'b0;
    end else if (strb.zcAccept) begin
      delayLat  <= delaySet;
      periodLat <= halfCnt;
      halfCnt   <= '0;
      delayCnt  <= '0;
      pulseCnt  <= '0;
      fired     <= 1'b0;
    end else begin
      if (strb.lost) begin
        halfCnt   <= '0;
        periodLat <= '0;
      end else if (strb.tick && halfCnt != CNT_W'(LOSS_TICKS)) begin
        halfCnt <= halfCnt + 1'b1;
      end

      if (strb.tick && delayCnt != '1)
        delayCnt <= delayCnt + 1'b1;

      if (strb.inhibit)
        pulseCnt <= '0;
      else if (fireNow)
        pulseCnt <= PUL_W'(PULSE_TICKS);
      else if (strb.tick && pulseCnt != '0)
        pulseCnt <= pulseCnt - 1'b1;

      if (fireNow)
        fired <= 1'b1;
    end
  end

  // R2: every qualified crossing re-arms the half cycle
  a_r2_rearm: assert property (@(posedge clk) disable iff (!rstN)
    strb.zcAccept |=> (!fired && delayCnt == '0));

  // R3: once fired, no second firing before the next crossing
  a_r3_single_fire: assert property (@(posedge clk) disable iff (!rstN)
    (fired && !strb.zcAccept) |=> fired);

  // R6: setpoint copy moves only at a crossing
  a_r6_latch_at_zc: assert property (@(posedge clk) disable iff (!rstN)
    !strb.zcAccept |=> $stable(delayLat));

  // R7: a pulse only starts when the delay fits the measured half cycle
  a_r7_no_late_fire: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gatePulse) |-> (CMP_W'(delayLat) < CMP_W'(periodLat)));
endmodule

// File: rtl/mains_fire_gen.sv
`timescale 1ns/1ps
module mains_fire_gen
  import mfg_pkg::*;
#(
  parameter int CLKS_PER_TICK = 2000,
  parameter int DEB_CLKS      = 64,
  parameter int BLANK_TICKS   = 200,
  parameter int LOSS_TICKS    = 1500,
  parameter int PULSE_TICKS   = 10,
  parameter int DELAY_W       = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               zcRaw,
  input  logic [DELAY_W-1:0] delaySet,
  input  logic               enable,
  input  logic               faultIn,
  input  logic               faultClr,
  output logic               gateOut,
  output logic               mainsOk
);
  fireStrb_t strb;
  logic      mainsLost;
  logic      faultLatch;
  logic      gatePulse;

  mfg_ctrl #(
    .CLKS_PER_TICK(CLKS_PER_TICK),
    .DEB_CLKS     (DEB_CLKS),
    .BLANK_TICKS  (BLANK_TICKS),
    .LOSS_TICKS   (LOSS_TICKS)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .zcRaw     (zcRaw),
    .enable    (enable),
    .faultIn   (faultIn),
    .faultClr  (faultClr),
    .strb      (strb),
    .mainsLost (mainsLost),
    .faultLatch(faultLatch)
  );

  mfg_datapath #(
    .DELAY_W    (DELAY_W),
    .PULSE_TICKS(PULSE_TICKS),
    .LOSS_TICKS (LOSS_TICKS)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .delaySet (delaySet),
    .gatePulse(gatePulse)
  );

  // fault path is combinational so the gate drops without a clock edge
  assign gateOut = gatePulse & ~faultIn & ~faultLatch;
  assign mainsOk = ~mainsLost;

  // R9: fault input forces the gate low
  a_r9_fault_blanks: assert property (@(posedge clk) disable iff (!rstN)
    faultIn |-> !gateOut);

  // R8: no gate while mains is absent
  a_r8_off_when_lost: assert property (@(posedge clk) disable iff (!rstN)
    !mainsOk |-> !gateOut);

  // R11: disabling stops the gate by the next cycle
  a_r11_enable_off: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !gateOut);
endmodule

// File: tb/sim_mains_fire_gen.sv
`timescale 1ns/1ps
module sim_mains_fire_gen;
  localparam int TD  = 4;    // clocks per tick
  localparam int DEB = 4;
  localparam int BLK = 20;
  localparam int LOS = 150;
  localparam int PUL = 3;
  localparam int DW  = 8;
  localparam int H50 = 400;  // 100 ticks
  localparam int H60 = 332;  // 83 ticks

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          zcRaw = 1'b0;
  logic [DW-1:0] delaySet = '0;
  logic          enable = 1'b0;
  logic          faultIn = 1'b0;
  logic          faultClr = 1'b0;
  logic          gateOut;
  logic          mainsOk;

  int nChecks = 0;
  int nErr = 0;

  always #2.5 clk = ~clk;

  mains_fire_gen #(
    .CLKS_PER_TICK(TD), .DEB_CLKS(DEB), .BLANK_TICKS(BLK),
    .LOSS_TICKS(LOS), .PULSE_TICKS(PUL), .DELAY_W(DW)
  ) u0 (
    .clk(clk), .rstN(rstN), .zcRaw(zcRaw), .delaySet(delaySet),
    .enable(enable), .faultIn(faultIn), .faultClr(faultClr),
    .gateOut(gateOut), .mainsOk(mainsOk)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One half cycle: toggle zcRaw, then watch the gate for hclk cycles.
  // mode 0: no pulse expected, 1: one timed pulse, 2: not checked
  task automatic runHalf(input int hclk, input int d, input int mode,
                         input int chgAt, input int chgD,
                         input int glAt, input int glLen,
                         input int fltAt, input string req);
    int rises = 0;
    int riseAt = -1;
    int width = 0;
    logic prev;
    @(negedge clk);
    delaySet = DW'(d);
    zcRaw = ~zcRaw;
    prev = gateOut;
    for (int i = 1; i < hclk; i++) begin
      @(negedge clk);
      if (i == chgAt) delaySet = DW'(chgD);
      if (i == glAt) zcRaw = ~zcRaw;
      if (glAt > 0 && i == glAt + glLen) zcRaw = ~zcRaw;
      if (i == fltAt) begin
        chk(gateOut == 1'b1, "R9", "gate before fault", int'(gateOut), 1);
        faultIn = 1'b1;
        #1;
        chk(gateOut == 1'b0, "R9", "gate right after fault", int'(gateOut), 0);
      end
      if (gateOut && !prev) begin
        rises++;
        if (riseAt < 0) riseAt = i;
      end
      if (gateOut) width++;
      prev = gateOut;
    end
    if (mode == 1) begin
      chk(rises == 1, req, "pulse count", rises, 1);
      chk(riseAt >= (d + 1) * TD && riseAt <= (d + 1) * TD + DEB + 8,
          req, "rise cycle", riseAt, (d + 1) * TD);
      chk(width == PUL * TD, req, "pulse width", width, PUL * TD);
    end else if (mode == 0) begin
      chk(rises == 0, req, "pulse count", rises, 0);
    end
  endtask

  task automatic plainHalf(input int hclk, input int d, input int mode,
                           input string req);
    runHalf(hclk, d, mode, -1, 0, -1, 0, -1, req);
  endtask

  initial begin
    #1000000;
    nErr++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    // R1 reset state
    chk(gateOut == 1'b0, "R1", "gate in reset", int'(gateOut), 0);
    chk(mainsOk == 1'b0, "R1", "mainsOk in reset", int'(mainsOk), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(gateOut == 1'b0, "R1", "gate after reset", int'(gateOut), 0);
    chk(mainsOk == 1'b0, "R1", "mainsOk after reset", int'(mainsOk), 0);
    enable = 1'b1;

    // R7: no measured length yet, so the first half cycle is silent
    plainHalf(H50, 10, 0, "R7");
    chk(mainsOk == 1'b1, "R8", "mainsOk after first crossing", int'(mainsOk), 1);

    // R2/R3 sweep at 50 Hz proportions, edges alternate in polarity
    for (int d = 0; d <= 90; d += 6) plainHalf(H50, d, 1, "R2");

    // R7 boundary: setpoint at or beyond 99 measured ticks is dropped
    plainHalf(H50, 99, 0, "R7");
    plainHalf(H50, 150, 0, "R7");
    plainHalf(H50, 255, 0, "R7");
    plainHalf(H50, 92, 1, "R7");

    // R12 at 60 Hz proportions
    plainHalf(H60, 20, 1, "R12");
    for (int d = 0; d <= 72; d += 8) plainHalf(H60, d, 1, "R12");
    plainHalf(H60, 82, 0, "R12");
    plainHalf(H60, 120, 0, "R12");

    // R6: mid-half setpoint change waits for the next crossing
    runHalf(H50, 30, 1, 20, 60, -1, 0, -1, "R6");
    plainHalf(H50, 60, 1, "R6");

    // R4: short spikes are ignored, before and after the pulse
    runHalf(H50, 40, 1, -1, 0, 100, 2, -1, "R4");
    runHalf(H50, 40, 1, -1, 0, 250, 2, -1, "R4");
    plainHalf(H50, 40, 1, "R4");

    // R5: longer glitch inside the hold-off does not re-arm
    runHalf(H50, 40, 1, -1, 0, 20, 8, -1, "R5");
    plainHalf(H50, 40, 1, "R5");

    // R11: disable
    enable = 1'b0;
    plainHalf(H50, 20, 0, "R11");
    plainHalf(H50, 20, 0, "R11");
    enable = 1'b1;
    plainHalf(H50, 20, 1, "R11");

    // R9/R10: fault mid-pulse, latch, clear rules
    runHalf(H50, 40, 2, -1, 0, -1, 0, (41 * TD) + 14, "R9");
    @(negedge clk); faultClr = 1'b1;
    @(negedge clk); faultClr = 1'b0;
    plainHalf(H50, 40, 0, "R10");
    faultIn = 1'b0;
    plainHalf(H50, 40, 0, "R10");
    @(negedge clk); faultClr = 1'b1;
    @(negedge clk); faultClr = 1'b0;
    plainHalf(H50, 40, 1, "R10");
    plainHalf(H50, 40, 1, "R10");

    // R8: mains loss and return
    plainHalf(H50, 10, 1, "R8");
    begin
      int rises = 0;
      logic prev = gateOut;
      for (int i = 0; i < 700; i++) begin
        @(negedge clk);
        if (gateOut && !prev) rises++;
        prev = gateOut;
      end
      chk(mainsOk == 1'b0, "R8", "mainsOk after silence", int'(mainsOk), 0);
      chk(rises == 0, "R8", "pulses during silence", rises, 0);
    end
    plainHalf(H50, 10, 0, "R8");
    chk(mainsOk == 1'b1, "R8", "mainsOk on return", int'(mainsOk), 1);
    plainHalf(H50, 10, 1, "R8");

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule